// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps the contents of a dynamic memory array alive while a single client uses it. The array holds a fixed number of internal rows, each of which must be recharged at least once in every retention window. Instead of sweeping all rows at once, the scheduler spreads the work out. It raises one row refresh every refresh interval, which is the retention window divided by the row count. A row pointer walks through the rows in order. Each refresh holds the array for a fixed number of cycles.

On the client side there is a request/grant exchange. A granted access owns the array for a fixed number of cycles. When the interval timer fires, a refresh becomes pending. No new access is granted while it waits, and it starts as soon as any access already in flight has finished. On the array side, the block drives a refresh strobe and the row being refreshed. It raises a one-cycle pulse each time the row pointer wraps back to row 0. It also accumulates the cycles lost to refresh, so the bandwidth loss can be measured against the configured interval.

All times are parameters counted in clock cycles. The defaults model a 16K-row array with a 50 ms window (about 305 cycles per row at 100 MHz) and a 100 ns row refresh.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst` is high and after its release, `client_gnt`, `ref_strobe` and `pass_done` are 0, `ref_row` is 0 and `lost_cycles` is 0 until the first refresh.
- R2: Counting rising clock edges after reset release, the interval timer fires on edges INTERVAL, 2·INTERVAL, 3·INTERVAL, and so on. With no client traffic, the first refresh strobe is high starting right after edge INTERVAL+1.
- R3: Every refresh holds `ref_strobe` high for exactly REFRESH_CYCLES consecutive cycles, and `client_gnt` is never high while `ref_strobe` is high.
- R4: Successive refreshes address rows 0, 1, 2, … ROWS-1, then row 0 again. `ref_row` is stable while the strobe is high.
- R5: `pass_done` is a one-cycle pulse. It appears in the first cycle after the refresh of row ROWS-1 ends, and at no other time.
- R6: Once the timer has fired for a refresh that has not yet started, no client grant is issued until that refresh has finished.
- R7: Let g be the edge of the most recent grant at or before the timer edge T. The refresh strobe then rises right after edge max(T, g+ACCESS_CYCLES)+1. A grant on the same edge as T is still honoured.
- R8: `lost_cycles` increases by one for every cycle in which `ref_strobe` was high, and holds otherwise.
- R9: `client_gnt` is a one-cycle pulse. Grants are at least ACCESS_CYCLES+1 edges apart. A request held in an idle array with nothing pending is granted on the next edge.
- R10: After E edges with no refresh in progress, `lost_cycles` is between (floor(E/INTERVAL)-1)·REFRESH_CYCLES and floor(E/INTERVAL)·REFRESH_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| client_req | input | 1 | Client asks for an array access |
| client_gnt | output | 1 | One-cycle grant; the access then owns the array for ACCESS_CYCLES cycles |
| ref_strobe | output | 1 | High while a row refresh is in progress |
| ref_row | output | $clog2(ROWS) | Row being refreshed |
| pass_done | output | 1 | One-cycle pulse when the row pointer wraps to 0 |
| lost_cycles | output | LOST_W | Running count of cycles spent refreshing |

## Verification
The interesting collision is the timer firing on the same edge that the arbiter grants a client request. Because the pending flag is not yet set at that decision, the grant wins, and the refresh must then wait out the whole access. A directed case raises the request one cycle before a known timer edge and checks three things: the grant arrives on exactly that edge, no further grant follows, and the strobe rises ACCESS_CYCLES+1 edges after the timer edge instead of one. During random traffic the same start-edge formula is applied to every refresh.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_ACCESS  = 2'd1,
    ARB_REFRESH = 2'd2
  } arb_state_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL = 305
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // Fires in the cycle whose closing edge completes a full interval.
  assign tick = (phase_q == LAST);
endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter
  import refsched_pkg::*;
#(
  parameter int ACCESS_CYCLES  = 4,
  parameter int REFRESH_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic req,
  output logic gnt,
  output logic strobe,
  output logic row_adv,
  output logic pending
);
  localparam int LONGEST = (ACCESS_CYCLES > REFRESH_CYCLES) ? ACCESS_CYCLES : REFRESH_CYCLES;
  localparam int CW = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] ACC_LAST = CW'(ACCESS_CYCLES - 1);
  localparam logic [CW-1:0] REF_LAST = CW'(REFRESH_CYCLES - 1);

  arb_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          gnt_q;
  logic          strobe_q;

  // Last refresh cycle: the row pointer moves on the same edge the strobe drops.
  assign row_adv = (state_q == ARB_REFRESH) && (cnt_q == REF_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ARB_IDLE;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      gnt_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      gnt_q <= 1'b0;
      if (tick) begin
        pend_q <= 1'b1;
      end
      case (state_q)
        ARB_IDLE: begin
          if (pend_q) begin
            state_q  <= ARB_REFRESH;
            cnt_q    <= '0;
            strobe_q <= 1'b1;
            pend_q   <= tick;
          end else if (req) begin
            state_q <= ARB_ACCESS;
            cnt_q   <= '0;
            gnt_q   <= 1'b1;
          end
        end
        ARB_ACCESS: begin
          if (cnt_q == ACC_LAST) begin
            state_q <= ARB_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ARB_REFRESH: begin
          if (cnt_q == REF_LAST) begin
            state_q  <= ARB_IDLE;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q  <= ARB_IDLE;
          cnt_q    <= '0;
          strobe_q <= 1'b0;
        end
      endcase
    end
  end

  assign gnt     = gnt_q;
  assign strobe  = strobe_q;
  assign pending = pend_q;
endmodule

// File: rtl/refresh_row_walker.sv
module refresh_row_walker #(
  parameter int ROWS = 16384
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  output logic [$clog2(ROWS)-1:0] row,
  output logic                    wrap
);
  localparam int RW = $clog2(ROWS);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic [RW-1:0] row_q;
  logic          wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (adv) begin
        if (row_q == LAST_ROW) begin
          row_q  <= '0;
          wrap_q <= 1'b1;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end
    end
  end

  assign row  = row_q;
  assign wrap = wrap_q;
endmodule

// File: rtl/refresh_loss_counter.sv
module refresh_loss_counter #(
  parameter int LOST_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  output logic [LOST_W-1:0] total
);
  logic [LOST_W-1:0] total_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
    end else if (busy) begin
      total_q <= total_q + 1'b1;
    end
  end

  assign total = total_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROWS           = 16384,
  parameter int INTERVAL       = 305,
  parameter int REFRESH_CYCLES = 10,
  parameter int ACCESS_CYCLES  = 4,
  parameter int LOST_W         = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    client_req,
  output logic                    client_gnt,
  output logic                    ref_strobe,
  output logic [$clog2(ROWS)-1:0] ref_row,
  output logic                    pass_done,
  output logic [LOST_W-1:0]       lost_cycles
);
  // INTERVAL must exceed ACCESS_CYCLES + REFRESH_CYCLES + 2 so that each
  // timer event is served before the next one arrives.
  logic timer_tick;
  logic row_adv;
  logic refresh_pend;

  refresh_interval_timer #(
    .INTERVAL(INTERVAL)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(timer_tick)
  );

  refresh_arbiter #(
    .ACCESS_CYCLES (ACCESS_CYCLES),
    .REFRESH_CYCLES(REFRESH_CYCLES)
  ) u_arb (
    .clk    (clk),
    .rst    (rst),
    .tick   (timer_tick),
    .req    (client_req),
    .gnt    (client_gnt),
    .strobe (ref_strobe),
    .row_adv(row_adv),
    .pending(refresh_pend)
  );

  refresh_row_walker #(
    .ROWS(ROWS)
  ) u_rows (
    .clk (clk),
    .rst (rst),
    .adv (row_adv),
    .row (ref_row),
    .wrap(pass_done)
  );

  refresh_loss_counter #(
    .LOST_W(LOST_W)
  ) u_loss (
    .clk  (clk),
    .rst  (rst),
    .busy (ref_strobe),
    .total(lost_cycles)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int ROWS           = 16384,
  parameter int REFRESH_CYCLES = 10,
  parameter int LOST_W         = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    client_gnt,
  input logic                    ref_strobe,
  input logic [$clog2(ROWS)-1:0] ref_row,
  input logic                    pass_done,
  input logic [LOST_W-1:0]       lost_cycles,
  input logic                    refresh_pend
);
  localparam int RW = $clog2(ROWS);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic [15:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (ref_strobe) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  assert_no_grant_in_refresh_R3: assert property (@(posedge clk) disable iff (rst)
    !(client_gnt && ref_strobe));

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_strobe) |-> run_q == 16'(REFRESH_CYCLES));

  assert_row_step_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_strobe) |-> ref_row == (($past(ref_row) == LAST_ROW) ? '0 : $past(ref_row) + 1'b1));

  assert_row_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ref_strobe && $past(ref_strobe)) |-> $stable(ref_row));

  assert_pass_on_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    pass_done |-> (ref_row == '0 && $fell(ref_strobe)));

  assert_pending_blocks_grant_R6: assert property (@(posedge clk) disable iff (rst)
    refresh_pend |=> !client_gnt);

  assert_loss_count_R8: assert property (@(posedge clk) disable iff (rst)
    $past(ref_strobe) |-> lost_cycles == $past(lost_cycles) + 1'b1);

  assert_loss_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(ref_strobe) |-> $stable(lost_cycles));

  assert_grant_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    client_gnt |=> !client_gnt);
endmodule

bind dram_refresh_sched refresh_sched_chk #(
  .ROWS          (ROWS),
  .REFRESH_CYCLES(REFRESH_CYCLES),
  .LOST_W        (LOST_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .client_gnt  (client_gnt),
  .ref_strobe  (ref_strobe),
  .ref_row     (ref_row),
  .pass_done   (pass_done),
  .lost_cycles (lost_cycles),
  .refresh_pend(refresh_pend)
);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int ROWS = 8;
  localparam int IVL  = 40;
  localparam int RC   = 5;
  localparam int AC   = 3;
  localparam int LW   = 32;
  localparam int RW   = $clog2(ROWS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          client_req = 1'b0;
  logic          client_gnt;
  logic          ref_strobe;
  logic [RW-1:0] ref_row;
  logic          pass_done;
  logic [LW-1:0] lost_cycles;

  dram_refresh_sched #(
    .ROWS(ROWS), .INTERVAL(IVL), .REFRESH_CYCLES(RC), .ACCESS_CYCLES(AC), .LOST_W(LW)
  ) uut (
    .clk(clk), .rst(rst), .client_req(client_req), .client_gnt(client_gnt),
    .ref_strobe(ref_strobe), .ref_row(ref_row), .pass_done(pass_done),
    .lost_cycles(lost_cycles)
  );

  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int edge_n = 0;
  bit finished = 0;
  bit mon_on = 0;

  always @(posedge clk) edge_n <= rst ? 0 : edge_n + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edge_n);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Monitor state (bench model of the requirements)
  int  nref = 0;        // completed refreshes
  int  run = 0;         // strobe-high cycles in current refresh
  int  hi_total = 0;    // strobe-high cycles seen overall
  int  last_gnt = -100; // edge of most recent grant
  bit  started = 0;
  bit  prev_strobe = 0;
  logic [RW-1:0] cur_row = '0;

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      int t_next;
      t_next = (nref + 1) * IVL;
      // R8: loss counter equals strobe-high cycles before this one
      chk(lost_cycles == LW'(hi_total), "R8", lost_cycles, hi_total);
      if (client_gnt) begin
        chk(!ref_strobe, "R3 grant during refresh", ref_strobe, 0);
        chk(started || edge_n <= t_next, "R6 grant while refresh pending", edge_n, t_next);
        chk(edge_n - last_gnt >= AC + 1, "R9 grant spacing", edge_n - last_gnt, AC + 1);
        last_gnt = edge_n;
      end
      if (ref_strobe && !prev_strobe) begin
        int g;
        g = (last_gnt <= t_next) ? last_gnt : -100;
        chk(edge_n == max2(t_next, g + AC) + 1, "R7 refresh start edge", edge_n, max2(t_next, g + AC) + 1);
        chk(ref_row == RW'(nref % ROWS), "R4 row order", ref_row, nref % ROWS);
        cur_row = ref_row;
        started = 1;
        run = 0;
      end
      if (ref_strobe) begin
        if (prev_strobe) chk(ref_row == cur_row, "R4 row stable", ref_row, cur_row);
        run++;
        hi_total++;
      end
      if (!ref_strobe && prev_strobe) begin
        chk(run == RC, "R3 strobe width", run, RC);
        nref++;
        started = 0;
        chk(pass_done == ((nref % ROWS) == 0), "R5 wrap pulse", pass_done, (nref % ROWS) == 0);
      end else begin
        if (pass_done) chk(0, "R5 stray wrap pulse", 1, 0);
      end
      prev_strobe = ref_strobe;
    end
  end

  task automatic wait_edge(input int n);
    while (edge_n < n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!client_gnt && !ref_strobe && !pass_done, "R1 reset outputs", {client_gnt, ref_strobe, pass_done}, 0);
    chk(ref_row == '0, "R1 reset row", ref_row, 0);
    chk(lost_cycles == '0, "R1 reset loss", lost_cycles, 0);
    rst = 1'b0;
    mon_on = 1;
    // R2: quiet start, first refresh one interval after reset
    wait_edge(IVL);
    chk(!ref_strobe && lost_cycles == '0, "R1 R2 idle before first refresh", ref_strobe, 0);
    wait_edge(IVL + 1);
    chk(ref_strobe == 1'b1, "R2 first refresh edge", ref_strobe, 1);
    chk(ref_row == '0, "R2 first row", ref_row, 0);
    // Idle over more than a full pass (wrap exercised, R5)
    wait_edge(11 * IVL + 10);
    chk(nref == 11, "R2 idle refresh count", nref, 11);
    // R9: request granted on next edge when idle
    wait_edge(11 * IVL + 15);
    client_req = 1'b1;
    @(negedge clk);
    chk(client_gnt == 1'b1, "R9 idle grant next edge", client_gnt, 1);
    client_req = 1'b0;
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      client_req = ($urandom % 3) != 0;
      @(negedge clk);
    end
    client_req = 1'b0;
    // Directed collision: grant on the same edge as the timer event
    begin
      int t;
      t = ((edge_n / IVL) + 2) * IVL;
      wait_edge(t - 1);
      client_req = 1'b1;
      @(negedge clk);
      chk(client_gnt == 1'b1, "R7 grant on timer edge", client_gnt, 1);
      client_req = 1'b1;
      wait_edge(t + AC);
      chk(ref_strobe == 1'b0, "R6 R7 refresh waits for access", ref_strobe, 0);
      chk(client_gnt == 1'b0, "R6 no grant while pending", client_gnt, 0);
      @(negedge clk);
      chk(ref_strobe == 1'b1, "R7 refresh after access", ref_strobe, 1);
      client_req = 1'b0;
    end
    // R10: loss fraction bounded by interval and refresh time
    wait_edge(edge_n + 3 * IVL);
    while (ref_strobe) @(negedge clk);
    begin
      longint ticks;
      ticks = edge_n / IVL;
      chk(lost_cycles <= ticks * RC && lost_cycles >= (ticks - 1) * RC, "R10 loss fraction", lost_cycles, ticks * RC);
    end
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule